// File: doc/BRIEF.md
# Saturating Q15 Vector Multiply-Add Unit

The unit is a pipelined 128-bit SIMD datapath for fixed-point signal processing. Each of its three operand vectors is split into eight signed 16-bit lanes. In every lane it multiplies A by B at full 32-bit precision. In rounding mode it adds a half-LSB bias of 0x4000, and it then shifts arithmetically right by 15 to return to Q15 scale. It then adds the C lane and clamps the sum to the signed 16-bit range. A typical use is a filter tap or a mixing stage, where C carries the running accumulator.

Operands enter through a valid/ready handshake and results leave through a second one. The multiply is done in the first register stage. The round, shift, add and clamp are done in the second. A sticky saturation flag records whether any lane of any result has clamped since software last cleared it.

Top module: `q15_vmadd`

## Requirements
- R1: All eight lanes compute the same function independently. Lane 0 is bits 127:112 of every vector and lane 7 is bits 15:0.
- R2: With round_en_i=1, the shifted term of a lane is floor((A*B + 16384) / 32768), computed on the signed product of the two lanes.
- R3: With round_en_i=0, the shifted term of a lane is floor(A*B / 32768), with no bias added.
- R4: The result lane is the shifted term plus the sign-extended C lane, clamped to the range -32768..32767. A sum inside that range passes through exactly.
- R5: sat_sticky_o becomes 1 when any lane of a result clamps. It stays 1 through later results that do not clamp.
- R6: A pulse on sat_clr_i clears sat_sticky_o. If a clamping result loads in the same cycle as a clear, the flag ends up 1.
- R7: When A = B = -32768, the shifted term is +32768 in both modes. With C=0 the result saturates to 32767, with C=-1 it is 32767 with no saturation, and with C=-32768 it is 0.
- R8: Saturation is judged on the final sum. With A=1, B=16384 and C=32767, rounding mode clamps to 32767 and sets the flag. Truncating mode gives 32767 without setting it.
- R9: An operand accepted on a rising edge (in_valid_i and in_ready_o both high) gives out_valid_o, result_o and its effect on sat_sticky_o after the next rising edge. While out_valid_o=1 and out_ready_i=0, in_ready_o is 0 and result_o holds steady.
- R10: After reset, out_valid_o=0 and sat_sticky_o=0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set is valid |
| in_ready_o | output | 1 | Unit accepts an operand set |
| round_en_i | input | 1 | 1 adds the 0x4000 bias before the shift |
| vec_a_i | input | 128 | Multiplicand lanes |
| vec_b_i | input | 128 | Multiplier lanes |
| vec_c_i | input | 128 | Addend lanes |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 128 | Saturated result lanes |
| sat_sticky_o | output | 1 | Sticky saturation flag |
| sat_clr_i | input | 1 | Clears the sticky flag |

## Verification
The assertions assume that the consumer may hold out_ready_i low for any length of time. They also assume that sat_clr_i may arrive in any cycle, and that a result is only meaningful while out_valid_o is high. The stimulus drives every input half a cycle away from the active edge and holds in_valid_i for exactly one accepted cycle per operation. Backpressure and clear pulses are applied only in the windows the directed and random sequences choose. Random operands are skewed toward the lane extremes so that the clamp boundaries and the -32768 squared case are hit often.

// File: rtl/q15_vmadd_pkg.sv
package q15_vmadd_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned VEC_W  = LANES * LANE_W;
  localparam int unsigned PROD_W = 2 * LANE_W;
endpackage

// File: rtl/q15_mul_stage.sv
module q15_mul_stage #(
  parameter int unsigned LANES  = q15_vmadd_pkg::LANES,
  parameter int unsigned LANE_W = q15_vmadd_pkg::LANE_W,
  localparam int unsigned VEC_W  = LANES * LANE_W,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     valid_i,
  input  logic                     round_i,
  input  logic [VEC_W-1:0]         a_i,
  input  logic [VEC_W-1:0]         b_i,
  input  logic [VEC_W-1:0]         c_i,
  output logic                     valid_o,
  output logic                     round_o,
  output logic [LANES*PROD_W-1:0]  prod_o,
  output logic [VEC_W-1:0]         c_o
);
  logic [LANES*PROD_W-1:0] prod_d;

  // lane 0 sits at the top of the vector
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [LANE_W-1:0] a_l, b_l;
    logic signed [PROD_W-1:0] p_l;
    assign a_l = a_i[VEC_W-1-i*LANE_W -: LANE_W];
    assign b_l = b_i[VEC_W-1-i*LANE_W -: LANE_W];
    assign p_l = PROD_W'(a_l) * PROD_W'(b_l);
    assign prod_d[LANES*PROD_W-1-i*PROD_W -: PROD_W] = p_l;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      round_o <= 1'b0;
      prod_o  <= '0;
      c_o     <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      if (valid_i) begin
        round_o <= round_i;
        prod_o  <= prod_d;
        c_o     <= c_i;
      end
    end
  end
endmodule

// File: rtl/q15_round_clamp.sv
module q15_round_clamp #(
  parameter int unsigned LANE_W = q15_vmadd_pkg::LANE_W,
  localparam int unsigned PROD_W = 2 * LANE_W,
  localparam int unsigned FRAC   = LANE_W - 1,
  localparam int unsigned SUM_W  = PROD_W - FRAC + 1
) (
  input  logic [PROD_W-1:0] prod_i,
  input  logic [LANE_W-1:0] c_i,
  input  logic              round_i,
  output logic [LANE_W-1:0] res_o,
  output logic              sat_o
);
  localparam logic signed [PROD_W-1:0] BIAS  = PROD_W'(1) << (FRAC - 1);
  localparam logic signed [SUM_W-1:0]  S_MAX = SUM_W'((1 << FRAC) - 1);
  localparam logic signed [SUM_W-1:0]  S_MIN = ~S_MAX;

  logic signed [PROD_W-1:0] biased, shifted;
  logic signed [SUM_W-1:0]  term, c_ext, sum;

  assign biased  = $signed(prod_i) + (round_i ? BIAS : '0);
  assign shifted = biased >>> FRAC;
  assign term    = shifted[SUM_W-1:0];
  assign c_ext   = {{(SUM_W-LANE_W){c_i[LANE_W-1]}}, c_i};
  // wide enough that +32768 + (-32768) never wraps
  assign sum     = term + c_ext;

  always_comb begin
    sat_o = 1'b1;
    if (sum > S_MAX)      res_o = S_MAX[LANE_W-1:0];
    else if (sum < S_MIN) res_o = S_MIN[LANE_W-1:0];
    else begin
      res_o = sum[LANE_W-1:0];
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/q15_sum_stage.sv
module q15_sum_stage #(
  parameter int unsigned LANES  = q15_vmadd_pkg::LANES,
  parameter int unsigned LANE_W = q15_vmadd_pkg::LANE_W,
  localparam int unsigned VEC_W  = LANES * LANE_W,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    valid_i,
  input  logic                    round_i,
  input  logic [LANES*PROD_W-1:0] prod_i,
  input  logic [VEC_W-1:0]        c_i,
  output logic                    valid_o,
  output logic [VEC_W-1:0]        res_o,
  output logic                    sat_load_o
);
  logic [VEC_W-1:0] res_d;
  logic [LANES-1:0] sat_l;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    q15_round_clamp #(.LANE_W(LANE_W)) u_rc (
      .prod_i  (prod_i[LANES*PROD_W-1-i*PROD_W -: PROD_W]),
      .c_i     (c_i[VEC_W-1-i*LANE_W -: LANE_W]),
      .round_i (round_i),
      .res_o   (res_d[VEC_W-1-i*LANE_W -: LANE_W]),
      .sat_o   (sat_l[i])
    );
  end

  assign sat_load_o = en_i & valid_i & (|sat_l);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/q15_vmadd.sv
module q15_vmadd #(
  parameter int unsigned LANES  = q15_vmadd_pkg::LANES,
  parameter int unsigned LANE_W = q15_vmadd_pkg::LANE_W,
  localparam int unsigned VEC_W  = LANES * LANE_W,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             round_en_i,
  input  logic [VEC_W-1:0] vec_a_i,
  input  logic [VEC_W-1:0] vec_b_i,
  input  logic [VEC_W-1:0] vec_c_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] result_o,
  output logic             sat_sticky_o,
  input  logic             sat_clr_i
);
  logic                    pipe_en;
  logic                    s1_valid, s1_round;
  logic [LANES*PROD_W-1:0] s1_prod;
  logic [VEC_W-1:0]        s1_c;
  logic                    sat_load;

  // whole pipe stalls when the output is held
  assign pipe_en    = ~(out_valid_o & ~out_ready_i);
  assign in_ready_o = pipe_en;

  q15_mul_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pipe_en),
    .valid_i (in_valid_i),
    .round_i (round_en_i),
    .a_i     (vec_a_i),
    .b_i     (vec_b_i),
    .c_i     (vec_c_i),
    .valid_o (s1_valid),
    .round_o (s1_round),
    .prod_o  (s1_prod),
    .c_o     (s1_c)
  );

  q15_sum_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pipe_en),
    .valid_i    (s1_valid),
    .round_i    (s1_round),
    .prod_i     (s1_prod),
    .c_i        (s1_c),
    .valid_o    (out_valid_o),
    .res_o      (result_o),
    .sat_load_o (sat_load)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sat_sticky_o <= 1'b0;
    else if (sat_load)  sat_sticky_o <= 1'b1;
    else if (sat_clr_i) sat_sticky_o <= 1'b0;
  end
endmodule

// File: rtl/q15_vmadd_chk.sv
module q15_vmadd_chk #(
  parameter int unsigned VEC_W = q15_vmadd_pkg::VEC_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [VEC_W-1:0] result_o,
  input logic             sat_sticky_o,
  input logic             sat_clr_i
);
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_sticky_o && !sat_clr_i) |=> sat_sticky_o);  // R5

  AST_STICKY_FALL_NEEDS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sat_sticky_o) |-> $past(sat_clr_i));  // R6

  AST_STICKY_RISE_WITH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_sticky_o) |-> out_valid_o);  // R9

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o)));  // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);  // R9
endmodule

bind q15_vmadd q15_vmadd_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .result_o     (result_o),
  .sat_sticky_o (sat_sticky_o),
  .sat_clr_i    (sat_clr_i)
);

// File: tb/q15_vmadd_tb_top.sv
`timescale 1ns/1ps
module q15_vmadd_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic         round_en_i = 1'b0;
  logic [127:0] vec_a_i = '0, vec_b_i = '0, vec_c_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic [127:0] result_o;
  logic         sat_sticky_o;
  logic         sat_clr_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit exp_sticky = 1'b0;

  always #2 clk_i = ~clk_i;

  q15_vmadd dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rep(input logic [15:0] v);
    return {8{v}};
  endfunction

  function automatic void model(input logic [127:0] a, b, c, input bit rnd,
                                output logic [127:0] r, output bit sat);
    sat = 1'b0;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      logic signed [15:0] al, bl, cl;
      longint x, y, p, s;
      al = a[127-16*i -: 16];
      bl = b[127-16*i -: 16];
      cl = c[127-16*i -: 16];
      x = al; y = bl;
      p = x * y + (rnd ? 64'sd16384 : 64'sd0);
      s = (p >>> 15) + longint'(cl);
      if (s > 32767) begin s = 32767; sat = 1'b1; end
      else if (s < -32768) begin s = -32768; sat = 1'b1; end
      r[127-16*i -: 16] = 16'(s);
    end
  endfunction

  // one accepted op; result checked after the second edge
  task automatic run_op(input logic [127:0] a, b, c, input bit rnd, input bit clr_on_load, input string tag);
    logic [127:0] er;
    bit es;
    model(a, b, c, rnd, er, es);
    @(negedge clk_i);
    vec_a_i = a; vec_b_i = b; vec_c_i = c; round_en_i = rnd; in_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    sat_clr_i = clr_on_load;
    @(posedge clk_i);
    @(negedge clk_i);
    sat_clr_i = 1'b0;
    exp_sticky = clr_on_load ? es : (exp_sticky | es);
    chk(out_valid_o === 1'b1, {tag, " R9 out_valid"}, 128'(out_valid_o), 128'd1);
    chk(result_o === er, {tag, " result"}, result_o, er);
    chk(sat_sticky_o === exp_sticky, {tag, " R5 sticky"}, 128'(sat_sticky_o), 128'(exp_sticky));
  endtask

  function automatic logic [15:0] rnd_lane();
    case ($urandom_range(0, 7))
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return 16'h8001;
      3: return 16'hffff;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [127:0] rnd_vec();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[16*i +: 16] = rnd_lane();
    return v;
  endfunction

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] va, hold;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R10 out_valid in reset", 128'(out_valid_o), 128'd0);
    chk(sat_sticky_o === 1'b0, "R10 sticky in reset", 128'(sat_sticky_o), 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R10 idle after reset",
        {126'd0, out_valid_o, in_ready_o}, 128'd1);

    // R1 lane order: lane i = (i+1)*1000, times 0.5
    for (int i = 0; i < 8; i++) va[127-16*i -: 16] = 16'((i + 1) * 1000);
    run_op(va, rep(16'h4000), '0, 1'b0, 1'b0, "R1 lanes");
    chk(result_o[127:112] == 16'd500 && result_o[15:0] == 16'd4000, "R1 lane0 at MSB",
        result_o, {16'd500, 96'd0, 16'd4000});

    // R2/R3 rounding vs truncating
    run_op(rep(16'd3), rep(16'h4000), '0, 1'b1, 1'b0, "R2 round pos");
    chk(result_o == rep(16'd2), "R2 round 3*0.5", result_o, rep(16'd2));
    run_op(rep(16'd3), rep(16'h4000), '0, 1'b0, 1'b0, "R3 trunc pos");
    chk(result_o == rep(16'd1), "R3 trunc 3*0.5", result_o, rep(16'd1));
    run_op(rep(-16'sd3), rep(16'h4000), '0, 1'b1, 1'b0, "R2 round neg");
    chk(result_o == rep(16'hffff), "R2 round -3*0.5", result_o, rep(16'hffff));
    run_op(rep(-16'sd3), rep(16'h4000), '0, 1'b0, 1'b0, "R3 trunc neg");
    chk(result_o == rep(16'hfffe), "R3 trunc -3*0.5", result_o, rep(16'hfffe));

    // R4 in-range passthrough and negative clamp
    run_op(rep(16'd100), rep(16'h7fff), rep(16'd1234), 1'b1, 1'b0, "R4 passthrough");
    chk(sat_sticky_o === 1'b0, "R4 no clamp no sticky", 128'(sat_sticky_o), 128'd0);
    run_op(rep(16'h8000), rep(16'h7fff), rep(16'h8000), 1'b0, 1'b0, "R4 neg clamp");
    chk(result_o == rep(16'h8000), "R4 clamp to -32768", result_o, rep(16'h8000));

    // R5 sticky survives a clean op
    run_op(rep(16'd1), rep(16'd1), rep(16'd7), 1'b0, 1'b0, "R5 clean after sat");
    chk(sat_sticky_o === 1'b1, "R5 sticky held", 128'(sat_sticky_o), 128'd1);

    // R6 standalone clear
    @(negedge clk_i); sat_clr_i = 1'b1;
    @(negedge clk_i); sat_clr_i = 1'b0;
    exp_sticky = 1'b0;
    chk(sat_sticky_o === 1'b0, "R6 clear", 128'(sat_sticky_o), 128'd0);

    // R7 -32768 squared
    run_op(rep(16'h8000), rep(16'h8000), '0, 1'b0, 1'b0, "R7 c=0");
    chk(result_o == rep(16'h7fff) && sat_sticky_o, "R7 c=0 saturates", result_o, rep(16'h7fff));
    run_op(rep(16'h8000), rep(16'h8000), rep(16'hffff), 1'b1, 1'b1, "R7 c=-1 with clear");
    chk(result_o == rep(16'h7fff) && !sat_sticky_o, "R7 c=-1 exact, R6 cleared", result_o, rep(16'h7fff));
    run_op(rep(16'h8000), rep(16'h8000), rep(16'h8000), 1'b1, 1'b0, "R7 c=min");
    chk(result_o == '0, "R7 c=-32768 gives 0", result_o, '0);

    // R8 bias pushes past max
    run_op(rep(16'd1), rep(16'h4000), rep(16'h7fff), 1'b0, 1'b0, "R8 trunc");
    chk(sat_sticky_o === 1'b0, "R8 trunc no sat", 128'(sat_sticky_o), 128'd0);
    run_op(rep(16'd1), rep(16'h4000), rep(16'h7fff), 1'b1, 1'b1, "R8 round with R6 clear");
    chk(sat_sticky_o === 1'b1, "R6 set wins over clear", 128'(sat_sticky_o), 128'd1);

    // R9 backpressure
    @(negedge clk_i); out_ready_i = 1'b0;
    run_op(rep(16'd10), rep(16'd20), rep(16'd30), 1'b0, 1'b0, "R9 stalled op");
    hold = result_o;
    chk(in_ready_o === 1'b0, "R9 ready low under stall", 128'(in_ready_o), 128'd0);
    @(negedge clk_i);
    vec_a_i = rep(16'h7fff); vec_b_i = rep(16'h7fff); vec_c_i = rep(16'h7fff); in_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(out_valid_o === 1'b1 && result_o === hold, "R9 result held", result_o, hold);
    chk(sat_sticky_o === exp_sticky, "R9 ignored input leaves sticky", 128'(sat_sticky_o), 128'(exp_sticky));
    out_ready_i = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R9 drained", 128'(out_valid_o), 128'd0);

    // random mix, R1-style full-vector compare
    for (int n = 0; n < 300; n++) begin
      run_op(rnd_vec(), rnd_vec(), rnd_vec(), 1'($urandom), ($urandom_range(0, 7) == 0), "R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule